// File: doc/BRIEF.md
# Host-Side Shift-Register Handshake Controller

This block is the host end of a byte-wide link to a small microcontroller. The bits are moved by a separate shift register. That register signals the end of each byte with a one-cycle `byte_done` strobe and presents the byte it received on `rx_byte`. The controller drives two handshake outputs: `xfer_n`, which is low while a transaction is in progress, and `hs_ack`, which acknowledges each byte by toggling. It watches one handshake input, `dev_req_n`, which the device pulls low when it wants attention.

A five-state machine runs the link. The states are idle, receive, receive-end, first-send-byte and send. Received bytes are gathered into a small buffer. When a packet is finished, the controller raises `pkt_done` for one cycle, together with the packet's length and contents. The host queues an outgoing packet with `tx_post`. The controller launches that packet only when the link is idle and the device is not requesting. The controller turns the shifter around with `shift_tx` and presents each outgoing byte on `tx_byte`.

If the device pulls its request line low while the first byte of a send is being shifted, that is a collision. The send is abandoned, the link returns to idle, and the queued packet stays pending so that it can be retried later.

Top module: `shl_host`

## Requirements
- R1: After reset, `xfer_n` = 1, `hs_ack` = 1, `shift_tx` = 0 and `pkt_done` = 0, and the controller is idle.
- R2: When idle, a `byte_done` with `dev_req_n` low starts reception: `xfer_n` goes low one cycle later and `hs_ack` is unchanged. The byte seen at that moment is not stored. A `byte_done` with `dev_req_n` high while idle and with nothing queued changes no output.
- R3: In receive, each `byte_done` stores `rx_byte` into the next buffer slot. If `dev_req_n` is still low, `hs_ack` toggles. Slot k appears on `pkt_data[8k+7:8k]`.
- R4: In receive, a `byte_done` with `dev_req_n` high still stores the byte, drives `hs_ack` and `xfer_n` high, and enters receive-end.
- R5: In receive-end, the next `byte_done` pulses `pkt_done` for exactly one cycle. At the same time `pkt_len` equals the number of stored bytes, and the stored count restarts from zero.
- R6: If `dev_req_n` is low at that receive-end `byte_done`, `xfer_n` goes low again and a new packet is received straight away, starting at slot 0.
- R7: The buffer holds RX_DEPTH (default 8) bytes. Further bytes are dropped, `pkt_len` saturates at RX_DEPTH, and `hs_ack` keeps toggling for every byte.
- R8: `tx_post` queues `tx_pkt` (byte k at bits [8k+7:8k]) with length `tx_len` only if no send is pending and 2 <= `tx_len` <= TX_DEPTH (default 4). Otherwise the post is ignored.
- R9: A pending send starts when the controller is idle and `dev_req_n` is high. One cycle later `shift_tx` = 1, `xfer_n` = 0 and `tx_byte` = byte 0. While `dev_req_n` is low, the send does not start.
- R10: In first-send-byte, a `byte_done` with `dev_req_n` high loads byte 1 onto `tx_byte` and toggles `hs_ack`.
- R11: In send, each `byte_done` loads the next byte and toggles `hs_ack`. The `byte_done` after the last byte sets `shift_tx` = 0, `hs_ack` = 1 and `xfer_n` = 1, and clears the pending send.
- R12: In first-send-byte, a `byte_done` with `dev_req_n` low is a collision: `shift_tx` = 0, `hs_ack` = 1, `xfer_n` = 1, and the controller returns to idle. The packet stays queued and restarts from byte 0 once `dev_req_n` is high again.
- R13: A device request seen at an idle `byte_done` takes priority over a queued send. When a packet ends in receive-end with `dev_req_n` high and a send queued, that send starts in the same cycle as the `pkt_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_req_n | input | 1 | Device request, active low |
| byte_done | input | 1 | One-cycle strobe: the shifter finished a byte |
| rx_byte | input | 8 | Byte captured by the shifter |
| tx_post | input | 1 | Queue an outgoing packet |
| tx_len | input | $clog2(TX_DEPTH+1) | Length of the posted packet |
| tx_pkt | input | TX_DEPTH*8 | Posted packet, byte k at [8k+7:8k] |
| xfer_n | output | 1 | Transaction in progress, active low |
| hs_ack | output | 1 | Acknowledge line, toggled once per byte |
| shift_tx | output | 1 | Shifter direction, 1 = host sends |
| tx_byte | output | 8 | Byte to load into the shifter |
| pkt_done | output | 1 | One-cycle pulse: a received packet is complete |
| pkt_len | output | $clog2(RX_DEPTH+1) | Number of bytes in the completed packet |
| pkt_data | output | RX_DEPTH*8 | Receive buffer, slot k at [8k+7:8k] |

## Verification
The receive path is driven from a vector table with three packet shapes:
- a three-byte packet that ends to idle;
- a two-byte packet whose end is followed at once by a new request;
- a one-byte packet.

Together these separate the toggle on a continued byte from the forced-high close, and they show that the slot index restarts at zero when packets run back to back. Directed sequences cover the following:
- ten bytes against an eight-slot buffer, to check saturation;
- rejected posts: too short, too long, and posted while a send is busy;
- a collision followed by a retry, which must restart at byte 0;
- a queued send blocked by a device request and then launched from receive-end.

// File: rtl/shl_pkg.sv
package shl_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_END,
        ST_TX_FIRST,
        ST_TX
    } shl_state_e;

endpackage

// File: rtl/shl_rx_store.sv
module shl_rx_store
    import shl_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    clr,
    input  logic [BYTE_W-1:0]       wr_data,
    output logic [CW-1:0]           cnt,
    output logic [DEPTH*BYTE_W-1:0] flat
);

    logic [CW-1:0] cnt_d, cnt_q;

    // The count stops at DEPTH; later bytes are dropped.
    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (wr_en && (cnt_q < CW'(DEPTH))) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [BYTE_W-1:0] slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (wr_en && !clr && (cnt_q == CW'(g))) begin
                slot_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign flat[g*BYTE_W +: BYTE_W] = slot_q;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/shl_tx_queue.sv
module shl_tx_queue
    import shl_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    post,
    input  logic [CW-1:0]           post_len,
    input  logic [DEPTH*BYTE_W-1:0] post_pkt,
    input  logic                    clr,
    input  logic [CW-1:0]           sel,
    output logic [CW-1:0]           cnt,
    output logic [BYTE_W-1:0]       sel_byte
);

    logic [CW-1:0]           cnt_d, cnt_q;
    logic [DEPTH*BYTE_W-1:0] pkt_d, pkt_q;
    logic                    accept;

    // A post is taken only into an empty queue, with a usable length.
    assign accept = post && (cnt_q == '0)
                    && (post_len >= CW'(2)) && (post_len <= CW'(DEPTH));

    always_comb begin
        cnt_d = cnt_q;
        pkt_d = pkt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (accept) begin
            cnt_d = post_len;
            pkt_d = post_pkt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pkt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            pkt_q <= pkt_d;
        end
    end

    always_comb begin
        sel_byte = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sel == CW'(i)) begin
                sel_byte = pkt_q[i*BYTE_W +: BYTE_W];
            end
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/shl_host.sv
module shl_host
    import shl_pkg::*;
#(
    parameter int unsigned RX_DEPTH = 8,
    parameter int unsigned TX_DEPTH = 4,
    localparam int unsigned RXC = $clog2(RX_DEPTH + 1),
    localparam int unsigned TXC = $clog2(TX_DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       dev_req_n,
    input  logic                       byte_done,
    input  logic [BYTE_W-1:0]          rx_byte,
    input  logic                       tx_post,
    input  logic [TXC-1:0]             tx_len,
    input  logic [TX_DEPTH*BYTE_W-1:0] tx_pkt,
    output logic                       xfer_n,
    output logic                       hs_ack,
    output logic                       shift_tx,
    output logic [BYTE_W-1:0]          tx_byte,
    output logic                       pkt_done,
    output logic [RXC-1:0]             pkt_len,
    output logic [RX_DEPTH*BYTE_W-1:0] pkt_data
);

    typedef struct packed {
        shl_state_e        st;
        logic              xfer_n;
        logic              ack;
        logic              dir;
        logic [BYTE_W-1:0] txb;
        logic [TXC-1:0]    tidx;
        logic              done;
        logic [RXC-1:0]    len;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st:     ST_IDLE,
        xfer_n: 1'b1,
        ack:    1'b1,
        dir:    1'b0,
        txb:    '0,
        tidx:   '0,
        done:   1'b0,
        len:    '0
    };

    ctl_t r_d, r_q;

    shl_state_e        st_q;
    logic [TXC-1:0]    tidx_q;
    logic              rx_wr, rx_clr, tx_clr;
    logic [RXC-1:0]    rx_cnt;
    logic [TXC-1:0]    tx_cnt;
    logic [TXC-1:0]    tx_sel;
    logic [BYTE_W-1:0] tx_sel_byte;

    assign st_q   = r_q.st;
    assign tidx_q = r_q.tidx;

    // Byte index into the queue, chosen from registered state alone.
    always_comb begin
        unique case (st_q)
            ST_TX_FIRST: tx_sel = TXC'(1);
            ST_TX:       tx_sel = tidx_q;
            default:     tx_sel = '0;
        endcase
    end

    shl_rx_store #(.DEPTH(RX_DEPTH)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rx_wr),
        .clr     (rx_clr),
        .wr_data (rx_byte),
        .cnt     (rx_cnt),
        .flat    (pkt_data)
    );

    shl_tx_queue #(.DEPTH(TX_DEPTH)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .post     (tx_post),
        .post_len (tx_len),
        .post_pkt (tx_pkt),
        .clr      (tx_clr),
        .sel      (tx_sel),
        .cnt      (tx_cnt),
        .sel_byte (tx_sel_byte)
    );

    always_comb begin
        r_d    = r_q;
        r_d.done = 1'b0;
        rx_wr  = 1'b0;
        rx_clr = 1'b0;
        tx_clr = 1'b0;

        unique case (st_q)
            ST_IDLE: begin
                if (byte_done && !dev_req_n) begin
                    r_d.st     = ST_RX;
                    r_d.xfer_n = 1'b0;
                end else if ((tx_cnt != '0) && dev_req_n) begin
                    r_d.st     = ST_TX_FIRST;
                    r_d.dir    = 1'b1;
                    r_d.txb    = tx_sel_byte;
                    r_d.xfer_n = 1'b0;
                end
            end

            ST_RX: begin
                if (byte_done) begin
                    rx_wr = 1'b1;
                    if (!dev_req_n) begin
                        r_d.ack = ~r_q.ack;
                    end else begin
                        r_d.ack    = 1'b1;
                        r_d.xfer_n = 1'b1;
                        r_d.st     = ST_RX_END;
                    end
                end
            end

            ST_RX_END: begin
                if (byte_done) begin
                    r_d.done = 1'b1;
                    r_d.len  = rx_cnt;
                    rx_clr   = 1'b1;
                    if (!dev_req_n) begin
                        r_d.xfer_n = 1'b0;
                        r_d.st     = ST_RX;
                    end else if (tx_cnt != '0) begin
                        // The queued send is launched directly from here.
                        r_d.st     = ST_TX_FIRST;
                        r_d.dir    = 1'b1;
                        r_d.txb    = tx_sel_byte;
                        r_d.xfer_n = 1'b0;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end

            ST_TX_FIRST: begin
                if (byte_done) begin
                    if (!dev_req_n) begin
                        // Collision: the device spoke during the first byte.
                        r_d.dir    = 1'b0;
                        r_d.ack    = 1'b1;
                        r_d.xfer_n = 1'b1;
                        r_d.st     = ST_IDLE;
                    end else begin
                        r_d.txb  = tx_sel_byte;
                        r_d.ack  = ~r_q.ack;
                        r_d.tidx = TXC'(2);
                        r_d.st   = ST_TX;
                    end
                end
            end

            ST_TX: begin
                if (byte_done) begin
                    if (r_q.tidx < tx_cnt) begin
                        r_d.txb  = tx_sel_byte;
                        r_d.tidx = r_q.tidx + 1'b1;
                        r_d.ack  = ~r_q.ack;
                    end else begin
                        r_d.dir    = 1'b0;
                        r_d.ack    = 1'b1;
                        r_d.xfer_n = 1'b1;
                        r_d.tidx   = '0;
                        tx_clr     = 1'b1;
                        r_d.st     = ST_IDLE;
                    end
                end
            end

            default: r_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= CTL_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign xfer_n   = r_q.xfer_n;
    assign hs_ack   = r_q.ack;
    assign shift_tx = r_q.dir;
    assign tx_byte  = r_q.txb;
    assign pkt_done = r_q.done;
    assign pkt_len  = r_q.len;

endmodule

// File: rtl/shl_host_chk.sv
module shl_host_chk
    import shl_pkg::*;
#(
    parameter int unsigned RX_DEPTH = 8,
    parameter int unsigned TX_DEPTH = 4,
    localparam int unsigned RXC = $clog2(RX_DEPTH + 1),
    localparam int unsigned TXC = $clog2(TX_DEPTH + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           dev_req_n,
    input logic           byte_done,
    input logic           xfer_n,
    input logic           hs_ack,
    input logic           shift_tx,
    input logic           pkt_done,
    input logic [RXC-1:0] pkt_len,
    input shl_state_e     st,
    input logic [TXC-1:0] tidx,
    input logic [TXC-1:0] tx_cnt
);

    a_r3_ack_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RX && byte_done && !dev_req_n) |=> (hs_ack != $past(hs_ack)));

    a_r4_rx_close: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RX && byte_done && dev_req_n) |=> (hs_ack && xfer_n && st == ST_RX_END));

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);

    a_r7_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> (pkt_len <= RXC'(RX_DEPTH)));

    a_r9_tx_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        shift_tx |-> !xfer_n);

    a_r11_tx_close: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TX && byte_done && tidx >= tx_cnt) |=> (!shift_tx && tx_cnt == '0));

    a_r12_collide: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TX_FIRST && byte_done && !dev_req_n)
            |=> (!shift_tx && hs_ack && xfer_n && st == ST_IDLE && tx_cnt != '0));

endmodule

bind shl_host shl_host_chk #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_req_n (dev_req_n),
    .byte_done (byte_done),
    .xfer_n    (xfer_n),
    .hs_ack    (hs_ack),
    .shift_tx  (shift_tx),
    .pkt_done  (pkt_done),
    .pkt_len   (pkt_len),
    .st        (st_q),
    .tidx      (tidx_q),
    .tx_cnt    (tx_cnt)
);

// File: tb/shl_host_tb.sv
`timescale 1ns/1ps
module shl_host_tb;

    localparam int RX_DEPTH = 8;
    localparam int TX_DEPTH = 4;
    localparam int RXC = $clog2(RX_DEPTH + 1);
    localparam int TXC = $clog2(TX_DEPTH + 1);

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   dev_req_n = 1'b1;
    logic                   byte_done = 1'b0;
    logic [7:0]             rx_byte = '0;
    logic                   tx_post = 1'b0;
    logic [TXC-1:0]         tx_len = '0;
    logic [TX_DEPTH*8-1:0]  tx_pkt = '0;
    logic                   xfer_n, hs_ack, shift_tx, pkt_done;
    logic [7:0]             tx_byte;
    logic [RXC-1:0]         pkt_len;
    logic [RX_DEPTH*8-1:0]  pkt_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    shl_host #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .dev_req_n(dev_req_n), .byte_done(byte_done),
        .rx_byte(rx_byte), .tx_post(tx_post), .tx_len(tx_len), .tx_pkt(tx_pkt),
        .xfer_n(xfer_n), .hs_ack(hs_ack), .shift_tx(shift_tx), .tx_byte(tx_byte),
        .pkt_done(pkt_done), .pkt_len(pkt_len), .pkt_data(pkt_data)
    );

    typedef struct packed {
        logic       bd;
        logic       rq;
        logic [7:0] d;
        logic       e_x;
        logic       e_a;
        logic       e_dn;
        logic [3:0] e_len;
        logic [7:0] e_b0;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 8'hAA, 1'b0, 1'b1, 1'b0, 4'd0, 8'h00},
        '{1'b1, 1'b0, 8'h11, 1'b0, 1'b0, 1'b0, 4'd0, 8'h00},
        '{1'b1, 1'b0, 8'h22, 1'b0, 1'b1, 1'b0, 4'd0, 8'h00},
        '{1'b1, 1'b1, 8'h33, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00},
        '{1'b1, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 4'd3, 8'h11},
        '{1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00},
        '{1'b1, 1'b0, 8'h99, 1'b0, 1'b1, 1'b0, 4'd0, 8'h00},
        '{1'b1, 1'b0, 8'h44, 1'b0, 1'b0, 1'b0, 4'd0, 8'h00},
        '{1'b1, 1'b1, 8'h55, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00},
        '{1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 4'd2, 8'h44},
        '{1'b1, 1'b1, 8'h66, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00},
        '{1'b1, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 4'd1, 8'h66},
        '{1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic evt(input logic bd, input logic rq, input logic [7:0] d);
        byte_done = bd;
        dev_req_n = rq;
        rx_byte   = d;
        @(negedge clk);
        byte_done = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic post(input int len, input logic [TX_DEPTH*8-1:0] pkt);
        tx_post = 1'b1;
        tx_len  = TXC'(len);
        tx_pkt  = pkt;
        @(negedge clk);
        tx_post = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1: reset state
        chk("R1", "xfer_n", int'(xfer_n), 1);
        chk("R1", "hs_ack", int'(hs_ack), 1);
        chk("R1", "shift_tx", int'(shift_tx), 0);
        chk("R1", "pkt_done", int'(pkt_done), 0);
        rst_n = 1'b1;
        idle(2);

        // R2: a byte with the request line high while idle is ignored
        evt(1'b1, 1'b1, 8'h5A);
        chk("R2", "xfer_n unchanged", int'(xfer_n), 1);
        chk("R2", "hs_ack unchanged", int'(hs_ack), 1);
        chk("R2", "no pkt_done", int'(pkt_done), 0);

        // Receive-path vector table (R2 R3 R4 R5 R6)
        for (int i = 0; i < NV; i++) begin
            evt(VEC[i].bd, VEC[i].rq, VEC[i].d);
            chk("R2/R4/R6", $sformatf("v%0d xfer_n", i), int'(xfer_n), int'(VEC[i].e_x));
            chk("R3", $sformatf("v%0d hs_ack", i), int'(hs_ack), int'(VEC[i].e_a));
            chk("R5", $sformatf("v%0d pkt_done", i), int'(pkt_done), int'(VEC[i].e_dn));
            if (VEC[i].e_dn) begin
                chk("R5", $sformatf("v%0d pkt_len", i), int'(pkt_len), int'(VEC[i].e_len));
                chk("R6", $sformatf("v%0d slot0", i), int'(pkt_data[7:0]), int'(VEC[i].e_b0));
            end
            if (i == 4) begin
                chk("R3", "slot1", int'(pkt_data[15:8]), 8'h22);
                chk("R3", "slot2", int'(pkt_data[23:16]), 8'h33);
            end
        end

        // R7: overflow of the eight-slot buffer
        begin
            logic exp_ack;
            evt(1'b1, 1'b0, 8'hEE);
            exp_ack = 1'b1;
            for (int i = 0; i < 9; i++) begin
                evt(1'b1, 1'b0, 8'(8'h30 + i));
                exp_ack = ~exp_ack;
                chk("R7", $sformatf("ack byte %0d", i), int'(hs_ack), int'(exp_ack));
            end
            evt(1'b1, 1'b1, 8'h39);
            chk("R7", "close xfer_n", int'(xfer_n), 1);
            evt(1'b1, 1'b1, 8'h00);
            chk("R7", "pkt_done", int'(pkt_done), 1);
            chk("R7", "pkt_len saturated", int'(pkt_len), RX_DEPTH);
            chk("R7", "slot0", int'(pkt_data[7:0]), 8'h30);
            chk("R7", "slot7", int'(pkt_data[63:56]), 8'h37);
        end

        // R8: rejected posts (too short, too long)
        post(1, 32'h000000C1);
        idle(2);
        chk("R8", "len 1 ignored", int'(shift_tx), 0);
        post(5, 32'hC4C3C2C1);
        idle(2);
        chk("R8", "len 5 ignored", int'(shift_tx), 0);

        // R9: blocked while the device requests, then started
        dev_req_n = 1'b0;
        post(3, 32'h00C3B2A1);
        idle(2);
        chk("R9", "blocked by request", int'(shift_tx), 0);
        dev_req_n = 1'b1;
        idle(1);
        chk("R9", "shift_tx", int'(shift_tx), 1);
        chk("R9", "xfer_n", int'(xfer_n), 0);
        chk("R9", "tx_byte0", int'(tx_byte), 8'hA1);

        // R12: collision on the first byte, then retry from byte 0
        evt(1'b1, 1'b0, 8'h00);
        chk("R12", "shift_tx", int'(shift_tx), 0);
        chk("R12", "hs_ack", int'(hs_ack), 1);
        chk("R12", "xfer_n", int'(xfer_n), 1);
        idle(2);
        chk("R12", "idle while request low", int'(shift_tx), 0);
        dev_req_n = 1'b1;
        idle(1);
        chk("R12", "retry shift_tx", int'(shift_tx), 1);
        chk("R12", "retry byte0", int'(tx_byte), 8'hA1);

        // R10: first byte accepted
        evt(1'b1, 1'b1, 8'h00);
        chk("R10", "tx_byte1", int'(tx_byte), 8'hB2);
        chk("R10", "hs_ack toggled", int'(hs_ack), 0);

        // R8: post while a send is pending is ignored
        post(2, 32'h0000E2E1);

        // R11: rest of the packet and close
        evt(1'b1, 1'b1, 8'h00);
        chk("R11", "tx_byte2", int'(tx_byte), 8'hC3);
        chk("R11", "hs_ack toggled", int'(hs_ack), 1);
        evt(1'b1, 1'b1, 8'h00);
        chk("R11", "shift_tx", int'(shift_tx), 0);
        chk("R11", "hs_ack", int'(hs_ack), 1);
        chk("R11", "xfer_n", int'(xfer_n), 1);
        idle(3);
        chk("R11", "pending cleared", int'(shift_tx), 0);
        chk("R8", "busy post ignored", int'(xfer_n), 1);

        // R13: request wins over queued send; send launched from receive-end
        dev_req_n = 1'b0;
        post(2, 32'h00002010);
        evt(1'b1, 1'b0, 8'h00);
        chk("R13", "receive wins xfer_n", int'(xfer_n), 0);
        chk("R13", "receive wins shift_tx", int'(shift_tx), 0);
        evt(1'b1, 1'b1, 8'h77);
        evt(1'b1, 1'b1, 8'h00);
        chk("R13", "pkt_done", int'(pkt_done), 1);
        chk("R13", "pkt_len", int'(pkt_len), 1);
        chk("R13", "launch shift_tx", int'(shift_tx), 1);
        chk("R13", "launch tx_byte", int'(tx_byte), 8'h10);
        chk("R13", "launch xfer_n", int'(xfer_n), 0);
        evt(1'b1, 1'b1, 8'h00);
        chk("R13", "tx_byte1", int'(tx_byte), 8'h20);
        evt(1'b1, 1'b1, 8'h00);
        chk("R13", "close shift_tx", int'(shift_tx), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule